// File: doc/BRIEF.md
# Dual-Port Byte-Lane Word Memory

This block is a 32-bit memory slave with two independent bus ports that share one storage array. The instruction port can only read. The data port can read and write, and it uses per-byte selects so that a write can change any subset of the four bytes in a word. The storage is split into four byte-wide dual-port RAM lanes. Lane g stores data bits [8g+7:8g] for both ports.

The two ports decode the same word index, so a word written through the data port at a high address is read back through the instruction port at the matching low address. Each port has its own two-state acknowledge machine. Its states are ST_IDLE and ST_ACK. The transition ST_IDLE to ST_ACK is taken on "accept", when cyc and stb are both high. The transition ST_ACK to ST_IDLE is taken unconditionally, as the "release". Memory access is performed on the accepting clock edge, so read data is presented in the same cycle as the acknowledge.

Top module: `wb_dual_ram`

## Requirements
- R1: After reset, both acknowledges are low and both read-data outputs are zero.
- R2: When a port's cyc and stb are high while its acknowledge is low, that acknowledge is high for exactly the next cycle. While cyc and stb are held high, the acknowledge is therefore high on every other cycle.
- R3: A port whose cyc or stb is low is not accepted. It gives no acknowledge, performs no write, and leaves its read data unchanged.
- R4: The word index is address bits [ADDR_W+1:2]. Address bits 1:0 and bits above ADDR_W+1 are ignored, so data written at 0x80000010 reads back at 0x00000010.
- R5: An accepted data-port request with we high writes byte lane g (data bits [8g+7:8g]) if and only if sel[g] is 1.
- R6: An accepted read on either port returns the full 32-bit word in the cycle in which that port's acknowledge is high.
- R7: A port's read data holds its value until that port's next accepted request.
- R8: Read-before-write. When the data port writes a word, the data port and an instruction read of the same word accepted on the same edge both return the word's previous contents.
- R9: An instruction read accepted on the edge after a data-port write returns the newly written word. The write and the read together take two cycles.
- R10: The two ports accept requests independently, so both acknowledges can be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_cyc | input | 1 | Instruction port bus cycle |
| i_stb | input | 1 | Instruction port strobe |
| i_adr | input | 32 | Instruction port byte address |
| i_dat_o | output | 32 | Instruction port read data |
| i_ack | output | 1 | Instruction port acknowledge |
| d_cyc | input | 1 | Data port bus cycle |
| d_stb | input | 1 | Data port strobe |
| d_we | input | 1 | Data port write enable |
| d_adr | input | 32 | Data port byte address |
| d_sel | input | 4 | Data port byte selects |
| d_dat_i | input | 32 | Data port write data |
| d_dat_o | output | 32 | Data port read data |
| d_ack | output | 1 | Data port acknowledge |

## Verification
If an acknowledge machine enters a wrong state, the symptom appears at the ports within one cycle. The acknowledge is missing, is doubled under a held strobe, or appears without a request. A wrong lane enable or a wrong address slice causes corrupted bytes in a later read of any word. The bench therefore writes every word through the aliased high address and reads every word back through the instruction port. It also sweeps all sixteen byte-select patterns on one word, and checks the same-edge and back-to-back orderings cycle by cycle.

// File: rtl/wb_dual_ram_pkg.sv
package wb_dual_ram_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ack_state_t;
endpackage

// File: rtl/dpram_byte_lane.sv
module dpram_byte_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANE_W-1:0] a_wdata,
    output logic [LANE_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [LANE_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Storage has no reset; only the read registers do.
    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            mem[a_addr] <= a_wdata;
        end
    end

    // Both read registers sample the pre-write contents (read-before-write).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_en) a_rdata <= mem[a_addr];
            if (b_en) b_rdata <= mem[b_addr];
        end
    end

    // R7
    lane_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));

endmodule

// File: rtl/wb_ack_fsm.sv
module wb_ack_fsm
    import wb_dual_ram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    output logic accept,
    output logic ack
);
    ack_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc && stb) begin
                    accept  = 1'b1;
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                ack     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R2
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R2
    req_gets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && cyc && stb) |=> ack);

    // R3
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc && stb) |=> !ack);

endmodule

// File: rtl/wb_dual_ram.sv
module wb_dual_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_cyc,
    input  logic        i_stb,
    input  logic [31:0] i_adr,
    output logic [31:0] i_dat_o,
    output logic        i_ack,
    input  logic        d_cyc,
    input  logic        d_stb,
    input  logic        d_we,
    input  logic [31:0] d_adr,
    input  logic [3:0]  d_sel,
    input  logic [31:0] d_dat_i,
    output logic [31:0] d_dat_o,
    output logic        d_ack
);
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int IDX_LO = 2;
    localparam int IDX_HI = ADDR_W + IDX_LO - 1;

    logic              i_accept, d_accept;
    logic [ADDR_W-1:0] i_idx, d_idx;

    assign i_idx = i_adr[IDX_HI:IDX_LO];
    assign d_idx = d_adr[IDX_HI:IDX_LO];

    logic unused_adr_bits;
    assign unused_adr_bits = ^{i_adr[31:IDX_HI+1], i_adr[IDX_LO-1:0],
                               d_adr[31:IDX_HI+1], d_adr[IDX_LO-1:0]};

    wb_ack_fsm u_i_ack (
        .clk(clk), .rst_n(rst_n), .cyc(i_cyc), .stb(i_stb),
        .accept(i_accept), .ack(i_ack)
    );

    wb_ack_fsm u_d_ack (
        .clk(clk), .rst_n(rst_n), .cyc(d_cyc), .stb(d_stb),
        .accept(d_accept), .ack(d_ack)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpram_byte_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_en    (d_accept),
            .a_we    (d_we && d_sel[g]),
            .a_addr  (d_idx),
            .a_wdata (d_dat_i[g*LANE_W +: LANE_W]),
            .a_rdata (d_dat_o[g*LANE_W +: LANE_W]),
            .b_en    (i_accept),
            .b_addr  (i_idx),
            .b_rdata (i_dat_o[g*LANE_W +: LANE_W])
        );
    end

    // R7
    d_dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_cyc && d_stb) |=> $stable(d_dat_o));

    // R10
    port_independent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_ack && i_cyc && i_stb && !d_ack && d_cyc && d_stb) |=> (i_ack && d_ack));

endmodule

// File: tb/wb_dual_ram_tb.sv
module wb_dual_ram_tb;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_cyc = 0, i_stb = 0;
    logic [31:0] i_adr = '0;
    logic [31:0] i_dat_o;
    logic        i_ack;
    logic        d_cyc = 0, d_stb = 0, d_we = 0;
    logic [31:0] d_adr = '0;
    logic [3:0]  d_sel = '0;
    logic [31:0] d_dat_i = '0;
    logic [31:0] d_dat_o;
    logic        d_ack;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] model [WORDS];

    always #5 clk = ~clk;

    wb_dual_ram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_cyc(i_cyc), .i_stb(i_stb), .i_adr(i_adr), .i_dat_o(i_dat_o), .i_ack(i_ack),
        .d_cyc(d_cyc), .d_stb(d_stb), .d_we(d_we), .d_adr(d_adr), .d_sel(d_sel),
        .d_dat_i(d_dat_i), .d_dat_o(d_dat_o), .d_ack(d_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pattern(input int w);
        return 32'h9E37_79B9 * (w + 1) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] sel);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (sel[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // Data-port write through high alias; checks ack pulse and optionally old data.
    task automatic d_write(input int w, input logic [3:0] sel, input logic [31:0] dat, input bit chk_old);
        logic [31:0] old = model[w];
        d_cyc = 1; d_stb = 1; d_we = 1; d_sel = sel; d_dat_i = dat;
        d_adr = 32'h8000_0000 | (32'(w) << 2) | 32'h3 | 32'h0100_0000;
        @(negedge clk);
        check(d_ack === 1'b1, "R2 d_ack after write", {31'b0, d_ack}, 32'h1);
        if (chk_old) check(d_dat_o === old, "R8 write returns old", d_dat_o, old);
        model[w] = merge(old, dat, sel);
        d_cyc = 0; d_stb = 0; d_we = 0;
        @(negedge clk);
        check(d_ack === 1'b0, "R2 d_ack single", {31'b0, d_ack}, 32'h0);
    endtask

    task automatic i_read(input int w, input string req);
        logic [31:0] got;
        i_cyc = 1; i_stb = 1;
        i_adr = (32'(w) << 2) | 32'h2 | 32'h1230_0000;
        @(negedge clk);
        check(i_ack === 1'b1, "R2 i_ack after read", {31'b0, i_ack}, 32'h1);
        check(i_dat_o === model[w], req, i_dat_o, model[w]);
        got = i_dat_o;
        i_cyc = 0; i_stb = 0; i_adr = 32'hFFFF_FFFC;
        @(negedge clk);
        check(i_ack === 1'b0, "R2 i_ack single", {31'b0, i_ack}, 32'h0);
        check(i_dat_o === got, "R7 i_dat_o holds", i_dat_o, got);
    endtask

    task automatic d_read(input int w, input string req);
        d_cyc = 1; d_stb = 1; d_we = 0; d_sel = 4'h0;
        d_adr = 32'h8000_0000 | (32'(w) << 2);
        @(negedge clk);
        check(d_dat_o === model[w], req, d_dat_o, model[w]);
        d_cyc = 0; d_stb = 0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_w, new_w;
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        #1;
        @(negedge clk);
        @(negedge clk);
        // R1
        check(i_ack === 1'b0 && d_ack === 1'b0, "R1 acks low in reset", {30'b0, i_ack, d_ack}, 32'h0);
        check(i_dat_o === 32'h0 && d_dat_o === 32'h0, "R1 read data zero", i_dat_o | d_dat_o, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(i_ack === 1'b0 && d_ack === 1'b0, "R1 acks low after reset", {30'b0, i_ack, d_ack}, 32'h0);

        // R4 / R6: fill every word via alias, read all back via instruction port
        for (int w = 0; w < WORDS; w++) d_write(w, 4'hF, pattern(w), 1'b0);
        for (int w = 0; w < WORDS; w++) i_read(w, "R4 R6 alias read");
        for (int w = 0; w < WORDS; w += 7) d_read(w, "R6 data port read");

        // R5: all byte-select patterns on one word
        for (int s = 0; s < 16; s++) begin
            d_write(5, 4'(s), 32'h1111_1111 * (s + 1), 1'b1);
            i_read(5, "R5 byte lane merge");
        end

        // R3: cyc or stb low: no ack, no write, data unchanged
        old_w = i_dat_o;
        d_cyc = 0; d_stb = 1; d_we = 1; d_sel = 4'hF; d_dat_i = 32'hDEAD_BEEF;
        d_adr = 32'h8000_0000 | (32'd9 << 2);
        i_cyc = 1; i_stb = 0; i_adr = 32'd9 << 2;
        @(negedge clk);
        check(d_ack === 1'b0 && i_ack === 1'b0, "R3 no ack", {30'b0, i_ack, d_ack}, 32'h0);
        check(i_dat_o === old_w, "R3 read data unchanged", i_dat_o, old_w);
        d_cyc = 1; d_stb = 0;
        @(negedge clk);
        check(d_ack === 1'b0, "R3 no ack stb low", {31'b0, d_ack}, 32'h0);
        d_cyc = 0; d_we = 0; i_cyc = 0;
        i_read(9, "R3 no write happened");

        // R2: held strobe gives ack every other cycle
        i_cyc = 1; i_stb = 1; i_adr = 32'd3 << 2;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(i_ack === ((k % 2) == 0), "R2 held strobe alternates", {31'b0, i_ack}, 32'((k % 2) == 0));
        end
        i_cyc = 0; i_stb = 0;
        @(negedge clk);

        // R8 / R10: same-edge write and instruction read of the same word
        old_w = model[12];
        new_w = 32'hABCD_EF12;
        d_cyc = 1; d_stb = 1; d_we = 1; d_sel = 4'hF; d_dat_i = new_w;
        d_adr = 32'h8000_0000 | (32'd12 << 2);
        i_cyc = 1; i_stb = 1; i_adr = 32'd12 << 2;
        @(negedge clk);
        check(i_ack === 1'b1 && d_ack === 1'b1, "R10 both acks", {30'b0, i_ack, d_ack}, 32'h3);
        check(i_dat_o === old_w, "R8 instr gets old word", i_dat_o, old_w);
        check(d_dat_o === old_w, "R8 data gets old word", d_dat_o, old_w);
        model[12] = new_w;
        d_cyc = 0; d_stb = 0; d_we = 0; i_cyc = 0; i_stb = 0;
        @(negedge clk);
        i_read(12, "R8 new word after");

        // R9: write then instruction read on the next edge
        d_cyc = 1; d_stb = 1; d_we = 1; d_sel = 4'hF; d_dat_i = 32'h0000_FFFF;
        d_adr = 32'h8000_0020;
        @(negedge clk);
        d_cyc = 0; d_stb = 0; d_we = 0;
        model[8] = 32'h0000_FFFF;
        i_cyc = 1; i_stb = 1; i_adr = 32'h0000_0020;
        @(negedge clk);
        check(i_ack === 1'b1, "R9 i_ack second cycle", {31'b0, i_ack}, 32'h1);
        check(i_dat_o === 32'h0000_FFFF, "R9 read sees new write", i_dat_o, 32'h0000_FFFF);
        i_cyc = 0; i_stb = 0;
        @(negedge clk);
        i_read(12, "R9 earlier word intact");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule